// File: doc/BRIEF.md
# Bounded Byte-Pattern Patch Engine

This block searches part of a byte-addressed program image, held in an on-chip single-port RAM, for a short byte string. When it finds the string it overwrites it in place with a replacement string of the same length. It then reads the rewritten bytes back to confirm that the RAM holds them. One start pulse runs the whole command: search, overwrite and read-back.

The search is limited to a window given by a base address and a byte count. No access ever leaves that window, so any header area kept outside it cannot be modified. A candidate position counts only when the whole pattern fits inside the window. An optional half-word alignment mode restricts candidates to even addresses, which suits 16-bit instruction patterns. Multi-byte instruction words are matched in memory byte order, least significant byte first.

The command ends in exactly one of four outcomes: success, pattern not found, read-back mismatch, or illegal pattern length. The outcome and the patched address stay on the outputs until the next accepted start.

Top module: `patch_engine`

## Requirements
- R1: Every RAM read and write address `a` satisfies `win_base <= a < win_base + win_size`. No byte outside the window is written. The caller keeps `win_base + win_size <= 2**AW`.
- R2: The replacement is written at the lowest candidate address where all `pat_len` bytes match. After a partial match fails, the next candidate is the following byte address, so overlapping occurrences are found.
- R3: A candidate `c` is only considered when `c + pat_len <= win_base + win_size`. A match that would run past the window end is not a match.
- R4: If no candidate matches, the command ends with `done=1` and `not_found=1`, and no RAM write occurs.
- R5: After writing, the engine reads back the same bytes. If any byte differs from the replacement, the command ends with `done=1` and `verify_fail=1`. Otherwise it ends with `done=1` and all error flags at 0.
- R6: Byte `i` of a pattern occupies bits `[8*i+7:8*i]` of `find_bytes` / `put_bytes` and is compared with (or written to) address `c + i`. A 32-bit little-endian word therefore has its least significant byte at `i = 0`.
- R7: With `even_only=1`, only candidates at even addresses (address bit 0 = 0) are considered. With `even_only=0`, every address is a candidate.
- R8: A `start` that arrives while `busy=1` is ignored. The running command finishes with its own latched parameters.
- R9: `done`, the error flags and `hit_addr` hold their values while the engine is idle. An accepted start clears `done` and the error flags, and raises `busy` in the next cycle.
- R10: A `pat_len` of 0 or greater than 16 ends the command in the cycle after start with `done=1`, `len_error=1`, `busy=0`, and no RAM access.
- R11: After reset `busy`, `done`, `not_found`, `verify_fail`, `len_error`, `ram_rd` and `ram_we` are all 0.
- R12: On success `hit_addr` equals the address of the first patched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command request |
| win_base | input | AW | First address of the searchable window |
| win_size | input | AW+1 | Window length in bytes |
| pat_len | input | LW | Pattern length in bytes (1 to MAXLEN legal) |
| even_only | input | 1 | Restrict candidates to even addresses |
| find_bytes | input | MAXLEN*8 | Search pattern, byte 0 in the low bits |
| put_bytes | input | MAXLEN*8 | Replacement pattern, byte 0 in the low bits |
| ram_addr | output | AW | RAM byte address |
| ram_rd | output | 1 | RAM read request; data is returned one cycle later |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_rd` |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command finished |
| not_found | output | 1 | No match in the window |
| verify_fail | output | 1 | Read-back mismatch |
| len_error | output | 1 | Illegal pattern length |
| hit_addr | output | AW | Address of the patched location |

## Verification
The bench goes after the following corner cases:
- Overlapping occurrences (`01 01 01 02` searched for `01 01 02`). An engine that resumed after the failed bytes instead of at the next address would report not-found.
- Two copies of the pattern. The lower one must be patched; a design that took the last match would patch the wrong address.
- A pattern just before the window base, and a pattern straddling the window end. A loose bound would either touch bytes outside the window or accept a clipped match. The exact-fit case at the window end guards against an off-by-one in the other direction.
- A little-endian instruction word preceded by the same bytes in reverse order. A byte-order error shows as the wrong location.
- An odd-address copy in even-only mode.
- A write-protected RAM byte, which must surface as `verify_fail`.
- Illegal lengths, and a start pulse during a long search. Each would corrupt the result if mishandled.

Random windows over a four-symbol alphabet create many partial matches, and each result is checked against a reference search of the whole RAM image.

// File: rtl/patch_pkg.sv
package patch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAND  = 3'd1,
        ST_RD    = 3'd2,
        ST_CMP   = 3'd3,
        ST_WR    = 3'd4,
        ST_VRD   = 3'd5,
        ST_VCMP  = 3'd6
    } pe_state_e;

    typedef logic [7:0] pe_byte_t;

endpackage

// File: rtl/pe_byte_pick.sv
module pe_byte_pick #(
    parameter  int NB = 16,
    localparam int IW = $clog2(NB)
) (
    input  logic [NB*8-1:0]        bytes_i,
    input  logic [IW-1:0]          sel_i,
    output patch_pkg::pe_byte_t    byte_o
);

    patch_pkg::pe_byte_t lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = bytes_i[g*8 +: 8];
    end

    assign byte_o = lane[sel_i];

endmodule

// File: rtl/pe_window.sv
module pe_window #(
    parameter  int AW = 10,
    parameter  int LW = 5,
    parameter  int IW = 4
) (
    input  logic [AW:0]    cand_i,
    input  logic [AW:0]    lim_i,
    input  logic [LW-1:0]  len_i,
    input  logic [IW-1:0]  idx_i,
    output logic           fits_o,
    output logic           odd_o,
    output logic [AW-1:0]  addr_o
);

    logic [AW+1:0] tail_w;

    assign tail_w = {1'b0, cand_i} + {{(AW+2-LW){1'b0}}, len_i};
    assign fits_o = (tail_w <= {1'b0, lim_i});
    assign odd_o  = cand_i[0];
    assign addr_o = cand_i[AW-1:0] + {{(AW-IW){1'b0}}, idx_i};

endmodule

// File: rtl/patch_engine.sv
module patch_engine #(
    parameter  int AW     = 10,
    parameter  int MAXLEN = 16,
    localparam int LW     = $clog2(MAXLEN + 1),
    localparam int IW     = $clog2(MAXLEN),
    localparam int PB     = MAXLEN * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   win_base,
    input  logic [AW:0]     win_size,
    input  logic [LW-1:0]   pat_len,
    input  logic            even_only,
    input  logic [PB-1:0]   find_bytes,
    input  logic [PB-1:0]   put_bytes,
    output logic [AW-1:0]   ram_addr,
    output logic            ram_rd,
    output logic            ram_we,
    output logic [7:0]      ram_wdata,
    input  logic [7:0]      ram_rdata,
    output logic            busy,
    output logic            done,
    output logic            not_found,
    output logic            verify_fail,
    output logic            len_error,
    output logic [AW-1:0]   hit_addr
);
    import patch_pkg::*;

    typedef struct packed {
        pe_state_e        st;
        logic [AW:0]      base;
        logic [AW:0]      lim;
        logic [LW-1:0]    len;
        logic             align;
        logic [PB-1:0]    spat;
        logic [PB-1:0]    rpat;
        logic [AW:0]      cand;
        logic [IW-1:0]    idx;
        logic             done;
        logic             nf;
        logic             vf;
        logic             le;
        logic [AW-1:0]    match;
    } eng_t;

    eng_t r_q, r_d;

    logic           fits_w, odd_w, last_w;
    logic [AW-1:0]  addr_w;
    pe_byte_t       sbyte_w, rbyte_w;
    logic [LW-1:0]  idx_ext_w;

    pe_window #(.AW(AW), .LW(LW), .IW(IW)) u_win (
        .cand_i (r_q.cand),
        .lim_i  (r_q.lim),
        .len_i  (r_q.len),
        .idx_i  (r_q.idx),
        .fits_o (fits_w),
        .odd_o  (odd_w),
        .addr_o (addr_w)
    );

    pe_byte_pick #(.NB(MAXLEN)) u_find (
        .bytes_i (r_q.spat),
        .sel_i   (r_q.idx),
        .byte_o  (sbyte_w)
    );

    pe_byte_pick #(.NB(MAXLEN)) u_put (
        .bytes_i (r_q.rpat),
        .sel_i   (r_q.idx),
        .byte_o  (rbyte_w)
    );

    assign idx_ext_w = {{(LW-IW){1'b0}}, r_q.idx};
    assign last_w    = ((idx_ext_w + 1'b1) == r_q.len);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base  = {1'b0, win_base};
                    r_d.lim   = {1'b0, win_base} + win_size;
                    r_d.len   = pat_len;
                    r_d.align = even_only;
                    r_d.spat  = find_bytes;
                    r_d.rpat  = put_bytes;
                    r_d.cand  = {1'b0, win_base};
                    r_d.idx   = '0;
                    r_d.nf    = 1'b0;
                    r_d.vf    = 1'b0;
                    r_d.le    = 1'b0;
                    if (pat_len == '0 || pat_len > LW'(MAXLEN)) begin
                        r_d.le   = 1'b1;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.done = 1'b0;
                        r_d.st   = ST_CAND;
                    end
                end
            end
            ST_CAND: begin
                if (!fits_w) begin
                    r_d.nf   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.align && odd_w) begin
                    r_d.cand = r_q.cand + 1'b1;
                end else begin
                    r_d.idx = '0;
                    r_d.st  = ST_RD;
                end
            end
            ST_RD: begin
                r_d.st = ST_CMP;
            end
            ST_CMP: begin
                if (ram_rdata != sbyte_w) begin
                    r_d.cand = r_q.cand + 1'b1;
                    r_d.st   = ST_CAND;
                end else if (last_w) begin
                    r_d.idx   = '0;
                    r_d.match = r_q.cand[AW-1:0];
                    r_d.st    = ST_WR;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_RD;
                end
            end
            ST_WR: begin
                if (last_w) begin
                    r_d.idx = '0;
                    r_d.st  = ST_VRD;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_VRD: begin
                r_d.st = ST_VCMP;
            end
            ST_VCMP: begin
                if (ram_rdata != rbyte_w) begin
                    r_d.vf   = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (last_w) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_VRD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ram_addr    = addr_w;
    assign ram_rd      = (r_q.st == ST_RD) || (r_q.st == ST_VRD);
    assign ram_we      = (r_q.st == ST_WR);
    assign ram_wdata   = rbyte_w;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign not_found   = r_q.nf;
    assign verify_fail = r_q.vf;
    assign len_error   = r_q.le;
    assign hit_addr    = r_q.match;

    AST_ACC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_we) |-> (({1'b0, ram_addr} >= r_q.base) && ({1'b0, ram_addr} < r_q.lim))); // R1
    AST_EVEN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD && r_q.idx == '0 && r_q.align) |-> !ram_addr[0]); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({not_found, verify_fail, len_error})); // R4
    AST_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        len_error |-> (!ram_rd && !ram_we && !busy)); // R10
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done, not_found, verify_fail, len_error, hit_addr})); // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable({r_q.base, r_q.lim, r_q.len, r_q.spat, r_q.rpat})); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5

endmodule

// File: tb/sim_patch_engine.sv
module sim_patch_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int MAXLEN = 16;
    localparam int LW = $clog2(MAXLEN + 1);
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] win_base = '0;
    logic [AW:0] win_size = '0;
    logic [LW-1:0] pat_len = '0;
    logic even_only = 1'b0;
    logic [MAXLEN*8-1:0] find_bytes = '0, put_bytes = '0;
    logic [AW-1:0] ram_addr;
    logic ram_rd, ram_we;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = '0;
    logic busy, done, not_found, verify_fail, len_error;
    logic [AW-1:0] hit_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    patch_engine #(.AW(AW), .MAXLEN(MAXLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .win_base(win_base), .win_size(win_size),
        .pat_len(pat_len), .even_only(even_only), .find_bytes(find_bytes), .put_bytes(put_bytes),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .not_found(not_found),
        .verify_fail(verify_fail), .len_error(len_error), .hit_addr(hit_addr)
    );

    // RAM model: single writer process
    logic [7:0] ram [MSZ];
    logic [7:0] expm [MSZ];
    logic load = 1'b0;
    int wp_addr = -1;
    int cur_lo = 0, cur_hi = 0;
    int acc_cnt = 0, wr_cnt = 0, oob_cnt = 0;

    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < MSZ; i++) ram[i] <= expm[i];
        end else begin
            if (ram_rd || ram_we) begin
                acc_cnt <= acc_cnt + 1;
                if (int'(ram_addr) < cur_lo || int'(ram_addr) >= cur_hi) oob_cnt <= oob_cnt + 1;
            end
            if (ram_we) begin
                wr_cnt <= wr_cnt + 1;
                if (int'(ram_addr) != wp_addr) ram[ram_addr] <= ram_wdata;
            end
            if (ram_rd) ram_rdata <= ram[ram_addr];
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [7:0] pbuf [MAXLEN];
    logic [7:0] rbuf [MAXLEN];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_find(input int base, input int size, input int len, input bit al);
        for (int c = base; c + len <= base + size; c++) begin
            bit hit = 1'b1;
            if (al && c[0]) continue;
            for (int i = 0; i < len; i++) if (expm[c+i] != pbuf[i]) hit = 1'b0;
            if (hit) return c;
        end
        return -1;
    endfunction

    // kind: 0 ok, 1 not found, 2 verify fail, 3 length error
    task automatic run_cmd(input int base, input int size, input int len, input bit al,
                           input int wp, input string req, input bit mid_start);
        int ekind, em, a0, w0, o0, n, mism;
        logic [3:0] st_snap;
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        wp_addr = wp; cur_lo = base; cur_hi = base + size;
        em = -1;
        if (len == 0 || len > MAXLEN) ekind = 3;
        else begin
            em = ref_find(base, size, len, al);
            if (em < 0) ekind = 1;
            else begin
                ekind = 0;
                for (int i = 0; i < len; i++) if (em + i != wp) expm[em+i] = rbuf[i];
                for (int i = 0; i < len; i++) if (expm[em+i] != rbuf[i]) ekind = 2;
            end
        end
        a0 = acc_cnt; w0 = wr_cnt; o0 = oob_cnt;
        win_base = AW'(base); win_size = (AW+1)'(size); pat_len = LW'(len); even_only = al;
        for (int i = 0; i < MAXLEN; i++) begin
            find_bytes[i*8 +: 8] = pbuf[i];
            put_bytes[i*8 +: 8] = rbuf[i];
        end
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R8", "busy before second start", int'(busy), 1);
            pat_len = '0; win_base = '0; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (busy && n < 40000) begin @(negedge clk); n++; end
        chk(!busy, req, "command finished", int'(busy), 0);
        chk(done && (not_found == (ekind == 1)) && (verify_fail == (ekind == 2)) && (len_error == (ekind == 3)),
            req, "outcome flags {done,nf,vf,le}", int'({done, not_found, verify_fail, len_error}),
            int'({1'b1, ekind == 1, ekind == 2, ekind == 3}));
        if (ekind == 0 || ekind == 2)
            chk(int'(hit_addr) == em, "R12", "hit_addr", int'(hit_addr), em);
        chk(oob_cnt == o0, "R1", "accesses outside window", oob_cnt - o0, 0);
        if (ekind == 1) chk(wr_cnt == w0, "R4", "writes on not-found", wr_cnt - w0, 0);
        if (ekind == 3) chk(acc_cnt == a0, "R10", "accesses on length error", acc_cnt - a0, 0);
        mism = 0;
        for (int i = 0; i < MSZ; i++) if (ram[i] !== expm[i]) mism++;
        chk(mism == 0, req, "RAM image mismatching bytes", mism, 0);
        st_snap = {done, not_found, verify_fail, len_error};
        repeat (4) @(negedge clk);
        chk({done, not_found, verify_fail, len_error} == st_snap && !busy, "R9", "status hold",
            int'({done, not_found, verify_fail, len_error}), int'(st_snap));
        wp_addr = -1;
    endtask

    task automatic fill(input int lo, input int hi, input logic [7:0] v);
        for (int i = lo; i < hi; i++) expm[i] = v;
    endtask

    task automatic setp(input int len, input logic [127:0] p, input logic [127:0] r);
        for (int i = 0; i < MAXLEN; i++) begin
            pbuf[i] = (i < len) ? p[i*8 +: 8] : 8'h00;
            rbuf[i] = (i < len) ? r[i*8 +: 8] : 8'h00;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < MSZ; i++) expm[i] = 8'hFF;
        @(negedge clk); load = 1'b1; @(negedge clk); load = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !not_found && !verify_fail && !len_error && !ram_rd && !ram_we,
            "R11", "reset outputs", int'({busy, done, not_found, verify_fail, len_error, ram_rd, ram_we}), 0);

        // R6: little-endian word; reversed copy earlier must not match
        fill(0, MSZ, 8'h00);
        expm[104] = 8'hac; expm[105] = 8'h0c; expm[106] = 8'h27; expm[107] = 8'hb7;
        expm[112] = 8'hb7; expm[113] = 8'h27; expm[114] = 8'h0c; expm[115] = 8'hac;
        setp(4, 128'hac0c27b7, 128'hbc0c47b7);
        run_cmd(100, 40, 4, 1'b0, -1, "R6", 1'b0);
        chk(ram[112] == 8'hb7 && ram[115] == 8'hbc, "R6", "LE word patched", int'(ram[115]), 8'hbc);

        // R2: overlapping candidates
        fill(0, MSZ, 8'h00);
        expm[200] = 8'h01; expm[201] = 8'h01; expm[202] = 8'h01; expm[203] = 8'h02;
        setp(3, 128'h020101, 128'h5a5a5a);
        run_cmd(200, 20, 3, 1'b0, -1, "R2", 1'b0);
        chk(hit_addr == 10'd201, "R2", "overlap match address", int'(hit_addr), 201);

        // R2: two copies, lowest wins
        fill(0, MSZ, 8'h00);
        expm[310] = 8'h7e; expm[311] = 8'h11; expm[330] = 8'h7e; expm[331] = 8'h11;
        setp(2, 128'h117e, 128'h2233);
        run_cmd(300, 50, 2, 1'b0, -1, "R2", 1'b0);

        // R1/R4: pattern just before window base only
        fill(0, MSZ, 8'h00);
        expm[398] = 8'h9c; expm[399] = 8'h9d;
        setp(2, 128'h9d9c, 128'h0101);
        run_cmd(400, 30, 2, 1'b0, -1, "R1", 1'b0);

        // R3: straddles window end -> not found
        fill(0, MSZ, 8'h00);
        expm[428] = 8'h31; expm[429] = 8'h32; expm[430] = 8'h33;
        setp(3, 128'h333231, 128'h444444);
        run_cmd(400, 30, 3, 1'b0, -1, "R3", 1'b0);
        // R3: exact fit at window end -> found
        run_cmd(400, 31, 3, 1'b0, -1, "R3", 1'b0);
        chk(hit_addr == 10'd428, "R3", "exact fit address", int'(hit_addr), 428);

        // R7: odd copy first, even copy later
        fill(0, MSZ, 8'h00);
        expm[501] = 8'h99; expm[502] = 8'h6a; expm[510] = 8'h99; expm[511] = 8'h6a;
        setp(2, 128'h6a99, 128'h0102);
        run_cmd(500, 20, 2, 1'b1, -1, "R7", 1'b0);
        chk(hit_addr == 10'd510, "R7", "even-only address", int'(hit_addr), 510);
        fill(0, MSZ, 8'h00);
        expm[501] = 8'h99; expm[502] = 8'h6a; expm[510] = 8'h99; expm[511] = 8'h6a;
        run_cmd(500, 20, 2, 1'b0, -1, "R7", 1'b0);
        chk(hit_addr == 10'd501, "R7", "any-address match", int'(hit_addr), 501);

        // R5: write-protected byte -> verify failure
        fill(0, MSZ, 8'h00);
        expm[600] = 8'h13; expm[601] = 8'h14; expm[602] = 8'h15; expm[603] = 8'h16;
        setp(4, 128'h16151413, 128'hd4c3b2a1);
        run_cmd(590, 30, 4, 1'b0, 602, "R5", 1'b0);

        // R10: illegal lengths
        setp(16, {16{8'h00}}, {16{8'h00}});
        run_cmd(0, 64, 0, 1'b0, -1, "R10", 1'b0);
        run_cmd(0, 64, 17, 1'b0, -1, "R10", 1'b0);

        // R8: start during a long search is ignored
        fill(0, MSZ, 8'h00);
        expm[780] = 8'hee; expm[781] = 8'hef;
        setp(2, 128'hefee, 128'h1234);
        run_cmd(700, 100, 2, 1'b0, -1, "R8", 1'b1);

        // random windows, small alphabet
        for (int it = 0; it < 25; it++) begin
            int base, size, len, pos;
            bit al;
            base = $urandom % 600; size = 16 + $urandom % 100; len = 1 + $urandom % 8;
            al = 1'($urandom % 2);
            for (int i = 0; i < MSZ; i++) expm[i] = 8'($urandom % 4);
            for (int i = 0; i < MAXLEN; i++) begin
                pbuf[i] = 8'($urandom % 4);
                rbuf[i] = 8'($urandom);
            end
            if ($urandom % 4 != 0) begin
                pos = base + $urandom % (size - len + 1);
                for (int i = 0; i < len; i++) expm[pos+i] = pbuf[i];
            end
            run_cmd(base, size, len, al, -1, "R2", 1'b0);
        end

        finish_run();
    end
endmodule